// File: doc/BRIEF.md
# Software-Refilled Address Translation Cache

This block caches translations from virtual page numbers to physical frame numbers for a 32-bit address space with 4 KB pages. Each lookup takes a virtual address. The upper 20 bits are the page number and the lower 12 bits are the byte offset within the page. One cycle later the block answers with either a hit or a miss. A hit carries the physical address, which is the stored frame number joined with the untouched offset. A miss raises a miss-exception flag. The hardware never fetches the translation itself, and it has no notion of where page tables live or how they are laid out.

Trap-handler software refills the buffer through a privileged install port. An install either names a slot or leaves the choice to a round-robin victim pointer. A privileged flush port invalidates every slot at once, which suits a context switch. Each slot can also carry an address-space tag. With tagging enabled, a lookup matches only slots whose tag equals the requesting process's tag, so a context switch needs no flush. Install or flush requests made without privilege change nothing and raise a one-cycle error flag.

Top module: `xlat_cache`

## Requirements
- R1: For every cycle with `lk_valid` high, `rsp_valid` is high in the next cycle, and `rsp_valid` is low otherwise. Exactly one of `rsp_hit` and `rsp_miss` is high while `rsp_valid` is high.
- R2: On a hit, `rsp_paddr[31:12]` is the frame number of the matching slot, and `rsp_paddr[11:0]` equals bits 11:0 of the looked-up address.
- R3: On a miss, `rsp_miss` is high, `rsp_hit` is low and `rsp_paddr` is zero. No slot is filled as a result.
- R4: A privileged install takes effect at the clock edge where it is presented. Lookups in later cycles hit. A lookup in the same cycle as the install sees the old contents.
- R5: A privileged flush invalidates every slot, so later lookups miss. An install presented in the same cycle as the flush survives it.
- R6: An install whose page number and tag match a valid slot overwrites that slot, even if a different index is requested. No two valid slots ever match the same page number and tag.
- R7: An install that matches no slot and has `wr_use_idx` low goes to the slot under the victim pointer. The pointer starts at 0 and then advances by one, modulo ENTRIES. An install with `wr_use_idx` high goes to slot `wr_idx` and leaves the pointer unchanged. A flush does not move the pointer.
- R8: When USE_PID is 1, a slot matches a lookup only if its stored tag equals `lk_pid` as well as the page number.
- R9: An install or flush presented with its privilege input low changes no slot. `priv_err` is high in the next cycle and low in every other cycle.
- R10: After reset all slots are invalid, the victim pointer is 0, and `rsp_valid` and `priv_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_pid | input | PID_W | Tag of the requesting process |
| wr_en | input | 1 | Install request |
| wr_priv | input | 1 | Install is made in privileged mode |
| wr_use_idx | input | 1 | Install to `wr_idx` rather than to the victim slot |
| wr_idx | input | $clog2(ENTRIES) | Explicit slot for the install |
| wr_vpn | input | 20 | Page number to install |
| wr_pfn | input | 20 | Frame number to install |
| wr_pid | input | PID_W | Tag to install |
| fl_en | input | 1 | Flush request |
| fl_priv | input | 1 | Flush is made in privileged mode |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | Translation found |
| rsp_miss | output | 1 | Miss exception |
| rsp_paddr | output | 32 | Physical address on a hit, zero otherwise |
| priv_err | output | 1 | Unprivileged install or flush was dropped |

## Verification
The bench builds the block with ENTRIES set to 4, PID_W set to 4 and tagging on. The small slot count lets a handful of installs wrap the victim pointer and evict the oldest slot, so eviction order and the effect of explicit-index installs on that order can be checked directly. With tagging on, the same page number can be held under two tags at once, which exercises tag separation and overwrite-on-match. The same-cycle install/lookup case and the same-cycle flush/install case are both driven as well.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W  = 32;
    localparam int OFF_W = 12;
    localparam int VPN_W = VA_W - OFF_W;
    localparam int PFN_W = 20;

    typedef logic [VPN_W-1:0] vpn_t;
    typedef logic [PFN_W-1:0] pfn_t;

    typedef enum logic [1:0] {
        SLOT_NONE,
        SLOT_MATCH,
        SLOT_INDEX,
        SLOT_VICTIM
    } slot_src_e;
endpackage

// File: rtl/tlb_tag_match.sv
module tlb_tag_match
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int PID_W   = 8,
    parameter bit USE_PID = 1'b1
) (
    input  logic [ENTRIES-1:0]            vld,
    input  logic [ENTRIES-1:0][VPN_W-1:0] vpn,
    input  logic [ENTRIES-1:0][PID_W-1:0] pid,
    input  vpn_t                          key_vpn,
    input  logic [PID_W-1:0]              key_pid,
    output logic [ENTRIES-1:0]            hits
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        if (USE_PID) begin : g_tagged
            assign hits[g] = vld[g] && (vpn[g] == key_vpn) && (pid[g] == key_pid);
        end else begin : g_plain
            assign hits[g] = vld[g] && (vpn[g] == key_vpn);
        end
    end
endmodule

// File: rtl/tlb_onehot_enc.sv
module tlb_onehot_enc #(
    parameter int N     = 16,
    localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (vec[i]) idx = idx | IW'(i);
        end
        any = |vec;
    end
endmodule

// File: rtl/tlb_victim_ptr.sv
module tlb_victim_ptr #(
    parameter int ENTRIES = 16,
    localparam int IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          advance,
    output logic [IW-1:0] ptr
);
    logic [IW-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (advance) begin
            ptr_d = (ptr_q == IW'(ENTRIES-1)) ? '0 : ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr = ptr_q;
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int PID_W   = 8,
    parameter bit USE_PID = 1'b1,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [VA_W-1:0]  lk_vaddr,
    input  logic [PID_W-1:0] lk_pid,
    input  logic             wr_en,
    input  logic             wr_priv,
    input  logic             wr_use_idx,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [PFN_W-1:0] wr_pfn,
    input  logic [PID_W-1:0] wr_pid,
    input  logic             fl_en,
    input  logic             fl_priv,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_miss,
    output logic [VA_W-1:0]  rsp_paddr,
    output logic             priv_err
);
    typedef struct packed {
        logic [ENTRIES-1:0]            vld;
        logic [ENTRIES-1:0][VPN_W-1:0] vpn;
        logic [ENTRIES-1:0][PFN_W-1:0] pfn;
        logic [ENTRIES-1:0][PID_W-1:0] pid;
        logic                          rsp_v;
        logic                          rsp_h;
        logic                          rsp_m;
        logic [VA_W-1:0]               rsp_pa;
        logic                          perr;
    } state_t;

    state_t st_d, st_q;

    logic [ENTRIES-1:0] lk_hits, wr_hits;
    logic [IDX_W-1:0]   lk_idx, wr_hit_idx, vic_idx, tgt_idx;
    logic               lk_any, wr_any, vic_adv;
    slot_src_e          tgt_src;

    // Lookup-side and install-side comparators both read the registered slots.
    tlb_tag_match #(.ENTRIES(ENTRIES), .PID_W(PID_W), .USE_PID(USE_PID)) u_lk_match (
        .vld(st_q.vld), .vpn(st_q.vpn), .pid(st_q.pid),
        .key_vpn(lk_vaddr[VA_W-1:OFF_W]), .key_pid(lk_pid), .hits(lk_hits)
    );

    tlb_tag_match #(.ENTRIES(ENTRIES), .PID_W(PID_W), .USE_PID(USE_PID)) u_wr_match (
        .vld(st_q.vld), .vpn(st_q.vpn), .pid(st_q.pid),
        .key_vpn(wr_vpn), .key_pid(wr_pid), .hits(wr_hits)
    );

    tlb_onehot_enc #(.N(ENTRIES)) u_lk_enc (.vec(lk_hits), .idx(lk_idx), .any(lk_any));
    tlb_onehot_enc #(.N(ENTRIES)) u_wr_enc (.vec(wr_hits), .idx(wr_hit_idx), .any(wr_any));

    tlb_victim_ptr #(.ENTRIES(ENTRIES)) u_victim (
        .clk(clk), .rst_n(rst_n), .advance(vic_adv), .ptr(vic_idx)
    );

    // Slot selection for an install: an existing match wins, then an explicit index, then the victim.
    always_comb begin
        tgt_src = SLOT_NONE;
        tgt_idx = vic_idx;
        if (wr_en && wr_priv) begin
            if (wr_any) begin
                tgt_src = SLOT_MATCH;
                tgt_idx = wr_hit_idx;
            end else if (wr_use_idx) begin
                tgt_src = SLOT_INDEX;
                tgt_idx = wr_idx;
            end else begin
                tgt_src = SLOT_VICTIM;
                tgt_idx = vic_idx;
            end
        end
        vic_adv = (tgt_src == SLOT_VICTIM);
    end

    always_comb begin
        st_d = st_q;

        st_d.rsp_v  = lk_valid;
        st_d.rsp_h  = lk_valid && lk_any;
        st_d.rsp_m  = lk_valid && !lk_any;
        st_d.rsp_pa = (lk_valid && lk_any) ? {st_q.pfn[lk_idx], lk_vaddr[OFF_W-1:0]} : '0;

        if (fl_en && fl_priv) st_d.vld = '0;

        if (tgt_src != SLOT_NONE) begin
            st_d.vld[tgt_idx] = 1'b1;
            st_d.vpn[tgt_idx] = wr_vpn;
            st_d.pfn[tgt_idx] = wr_pfn;
            st_d.pid[tgt_idx] = wr_pid;
        end

        st_d.perr = (wr_en && !wr_priv) || (fl_en && !fl_priv);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.rsp_v;
    assign rsp_hit   = st_q.rsp_h;
    assign rsp_miss  = st_q.rsp_m;
    assign rsp_paddr = st_q.rsp_pa;
    assign priv_err  = st_q.perr;
endmodule

// File: rtl/tlb_chk.sv
module tlb_chk #(
    parameter int ENTRIES = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lk_valid,
    input logic [11:0]        lk_off,
    input logic               wr_en,
    input logic               wr_priv,
    input logic               fl_en,
    input logic               fl_priv,
    input logic               rsp_valid,
    input logic               rsp_hit,
    input logic               rsp_miss,
    input logic [31:0]        rsp_paddr,
    input logic               priv_err,
    input logic [ENTRIES-1:0] hit_vec
);
    a_r1_resp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);

    a_r1_no_resp_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid);

    a_r1_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_hit != rsp_miss));

    a_r2_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (rsp_hit -> (rsp_paddr[11:0] == $past(lk_off))));

    a_r3_miss_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> (rsp_paddr == 32'h0));

    a_r5_flush_then_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_en && fl_priv && !wr_en) ##1 lk_valid |=> rsp_miss);

    a_r6_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    a_r9_flag_raised: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_en && !wr_priv) || (fl_en && !fl_priv)) |=> priv_err);

    a_r9_flag_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !((wr_en && !wr_priv) || (fl_en && !fl_priv)) |=> !priv_err);
endmodule

bind xlat_cache tlb_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_off(lk_vaddr[11:0]),
    .wr_en(wr_en), .wr_priv(wr_priv), .fl_en(fl_en), .fl_priv(fl_priv),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_paddr(rsp_paddr), .priv_err(priv_err), .hit_vec(lk_hits)
);

// File: tb/xlat_cache_tb.sv
module xlat_cache_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N   = 4;
    localparam int PW  = 4;
    localparam int IW  = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lk_valid = 1'b0;
    logic [31:0]   lk_vaddr = '0;
    logic [PW-1:0] lk_pid = '0;
    logic          wr_en = 1'b0, wr_priv = 1'b0, wr_use_idx = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic [19:0]   wr_vpn = '0, wr_pfn = '0;
    logic [PW-1:0] wr_pid = '0;
    logic          fl_en = 1'b0, fl_priv = 1'b0;
    logic          rsp_valid, rsp_hit, rsp_miss, priv_err;
    logic [31:0]   rsp_paddr;

    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;

    logic [32:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    xlat_cache #(.ENTRIES(N), .PID_W(PW), .USE_PID(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_pid(lk_pid),
        .wr_en(wr_en), .wr_priv(wr_priv), .wr_use_idx(wr_use_idx), .wr_idx(wr_idx),
        .wr_vpn(wr_vpn), .wr_pfn(wr_pfn), .wr_pid(wr_pid), .fl_en(fl_en), .fl_priv(fl_priv),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_paddr(rsp_paddr), .priv_err(priv_err)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Monitor: pops one expected result per response, sampled at the falling edge.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check("R1 unexpected response", 64'(rsp_valid), 64'h0);
            end else begin
                logic [32:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, {30'h0, rsp_hit, rsp_miss, rsp_paddr}, {30'h0, e[32], ~e[32], e[31:0]});
            end
        end
    end

    task automatic set_lookup(input logic [31:0] va, input logic [PW-1:0] pid,
                              input logic hit, input logic [19:0] pfn, input string tag);
        lk_valid = 1'b1;
        lk_vaddr = va;
        lk_pid   = pid;
        exp_q.push_back({hit, hit ? {pfn, va[11:0]} : 32'h0});
        tag_q.push_back(tag);
    endtask

    task automatic set_write(input logic [19:0] vpn, input logic [19:0] pfn, input logic [PW-1:0] pid,
                             input logic priv, input logic use_idx, input logic [IW-1:0] idx);
        wr_en = 1'b1; wr_priv = priv; wr_use_idx = use_idx; wr_idx = idx;
        wr_vpn = vpn; wr_pfn = pfn; wr_pid = pid;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        lk_valid = 1'b0; wr_en = 1'b0; wr_priv = 1'b0; wr_use_idx = 1'b0;
        fl_en = 1'b0; fl_priv = 1'b0;
    endtask

    task automatic lookup(input logic [31:0] va, input logic [PW-1:0] pid,
                          input logic hit, input logic [19:0] pfn, input string tag);
        set_lookup(va, pid, hit, pfn, tag);
        step();
    endtask

    task automatic install(input logic [19:0] vpn, input logic [19:0] pfn, input logic [PW-1:0] pid,
                           input logic use_idx, input logic [IW-1:0] idx);
        set_write(vpn, pfn, pid, 1'b1, use_idx, idx);
        step();
        check("R9 no flag on privileged install", 64'(priv_err), 64'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        mismatched++;
        $display("FAIL R1 watchdog act=running exp=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R10: reset state
        check("R10 rsp_valid after reset", 64'(rsp_valid), 64'h0);
        check("R10 priv_err after reset", 64'(priv_err), 64'h0);
        rst_n = 1'b1;
        step();

        // R3/R10: empty buffer misses
        lookup(32'h1234_5678, 4'd1, 1'b0, 20'h0, "R3 R10 empty buffer miss");
        lookup(32'h0000_0000, 4'd0, 1'b0, 20'h0, "R3 miss at zero");

        // R2/R4/R7: install to victim slot 0, then hit
        install(20'h12345, 20'hABCDE, 4'd1, 1'b0, '0);
        lookup(32'h1234_5678, 4'd1, 1'b1, 20'hABCDE, "R2 R4 hit after install");
        lookup(32'h1234_5FFF, 4'd1, 1'b1, 20'hABCDE, "R2 offset all ones");

        // R4: same-cycle install and lookup sees old contents (slot 1)
        set_write(20'h00777, 20'h33333, 4'd1, 1'b1, 1'b0, '0);
        set_lookup(32'h0077_7123, 4'd1, 1'b0, 20'h0, "R4 same-cycle lookup sees old");
        step();
        lookup(32'h0077_7123, 4'd1, 1'b1, 20'h33333, "R4 later lookup hits");

        // R8: tag separation (slot 2)
        lookup(32'h1234_5678, 4'd2, 1'b0, 20'h0, "R8 other tag misses");
        install(20'h12345, 20'h11111, 4'd2, 1'b0, '0);
        lookup(32'h1234_5678, 4'd2, 1'b1, 20'h11111, "R8 tag 2 own frame");
        lookup(32'h1234_5678, 4'd1, 1'b1, 20'hABCDE, "R8 tag 1 unchanged");

        // R6: matching install overrides explicit index 3, lands in slot 0
        install(20'h12345, 20'h22222, 4'd1, 1'b1, 2'd3);
        lookup(32'h1234_5001, 4'd1, 1'b1, 20'h22222, "R6 overwrite in place");

        // R9: unprivileged install and flush are dropped and flagged
        set_write(20'h0AAAA, 20'h44444, 4'd1, 1'b0, 1'b0, '0);
        step();
        check("R9 flag after unprivileged install", 64'(priv_err), 64'h1);
        step();
        check("R9 flag lasts one cycle", 64'(priv_err), 64'h0);
        lookup(32'h0AAA_A000, 4'd1, 1'b0, 20'h0, "R9 unprivileged install ignored");
        fl_en = 1'b1; fl_priv = 1'b0;
        step();
        check("R9 flag after unprivileged flush", 64'(priv_err), 64'h1);
        lookup(32'h1234_5001, 4'd1, 1'b1, 20'h22222, "R9 unprivileged flush ignored");

        // R7: pointer at 3; fill slot 3, then wrap to slot 0 and evict 12345/tag1
        install(20'h0A000, 20'h50000, 4'd1, 1'b0, '0);
        install(20'h0B000, 20'h60000, 4'd1, 1'b0, '0);
        lookup(32'h1234_5001, 4'd1, 1'b0, 20'h0, "R7 wrap evicts slot 0");
        lookup(32'h0077_7000, 4'd1, 1'b1, 20'h33333, "R7 slot 1 kept");
        lookup(32'h0A00_0010, 4'd1, 1'b1, 20'h50000, "R7 slot 3 filled");
        lookup(32'h0B00_0020, 4'd1, 1'b1, 20'h60000, "R7 slot 0 refilled");
        // explicit index 2 evicts 12345/tag2; pointer stays at 1
        install(20'h0C000, 20'h70000, 4'd1, 1'b1, 2'd2);
        lookup(32'h1234_5678, 4'd2, 1'b0, 20'h0, "R7 explicit index evicts slot 2");
        install(20'h0D000, 20'h80000, 4'd1, 1'b0, '0);
        lookup(32'h0077_7000, 4'd1, 1'b0, 20'h0, "R7 pointer held, slot 1 evicted");
        lookup(32'h0C00_0000, 4'd1, 1'b1, 20'h70000, "R7 explicit slot kept");
        lookup(32'h0D00_0ABC, 4'd1, 1'b1, 20'h80000, "R7 victim install hits");

        // R5: privileged flush with a same-cycle install
        fl_en = 1'b1; fl_priv = 1'b1;
        set_write(20'h0E000, 20'h90000, 4'd3, 1'b1, 1'b0, '0);
        step();
        check("R9 no flag on privileged flush", 64'(priv_err), 64'h0);
        lookup(32'h0A00_0010, 4'd1, 1'b0, 20'h0, "R5 flushed slot misses");
        lookup(32'h0D00_0ABC, 4'd1, 1'b0, 20'h0, "R5 flushed slot misses 2");
        lookup(32'h0E00_0FED, 4'd3, 1'b1, 20'h90000, "R5 same-cycle install survives");

        step();
        step();
        check("R1 all responses seen", 64'(exp_q.size()), 64'h0);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule